// File: doc/BRIEF.md
# Serial Transmit Formatter with Companding

This block is the transmit half of a synchronous serial port. Software writes a small configuration word and then writes data words into a one-entry transmit data register. At the next bit tick the block loads the waiting word into its frame register and shifts it out on a serial data pin. A frame-sync pin is high during the first bit of each frame. Before it is sent, each word is formatted in one of four ways:
- right-justified with the upper bits cleared,
- right-justified with the upper bits copied from the sample's sign bit,
- compressed to an 8-bit mu-law code,
- compressed to an 8-bit A-law code.

A fixed divider sets the bit period. A one-cycle interrupt pulse asks for the next data word. It fires when the port is switched on and again each time a word moves from the data register into the frame register. When the port is switched off, both pin output-enables drop, the pending word is dropped and the divider and shifter are held at rest.

The controller has three states:
- OFF: the port is disabled.
- IDLE: the port is enabled and no frame is running.
- SHIFT: a frame is going out.

Its transitions are:
- OFF→IDLE on the first cycle with the enable bit set.
- IDLE→SHIFT on a bit tick with the data register full (the load).
- SHIFT→IDLE on the bit tick that ends the last bit of the frame.
- Any state→OFF as soon as the enable bit reads 0.

Top module: `ser_tx_fmt`

## Requirements
- R1: Configuration bit 0 is the enable. While it is 0, the outputs are held as follows: `sd_oe`, `fs_oe`, `sd_out` and `fs_out` are 0, data writes are ignored, and any unsent word is discarded, so re-enabling starts no frame.
- R2: A configuration write that sets bit 0 while the port is off makes `tx_irq` high for exactly the one cycle right after the write. The output-enables are high from that same cycle.
- R3: Format code 00 in configuration bits 3:2 sends a 16-bit frame. The frame holds the low W bits of the data word with all higher bits 0.
- R4: Format code 01 sends a 16-bit frame. The frame holds the low W bits of the data word, and every higher bit equals data bit W-1.
- R5: Format code 10 sends an 8-bit frame holding the standard mu-law code of the 16-bit two's-complement word, computed as follows. Drop 2 LSBs. Take the magnitude clipped to 8159 and add a bias of 33. The segment is the leading-one position above bit 5, and the mantissa is the 4 bits below the leading one. The code is inverted, with bit 7 set for non-negative input.
- R6: Format code 11 sends an 8-bit frame holding the standard A-law code of the 16-bit word, computed as follows. Drop 3 LSBs and one's-complement negative values. Segments 0 and 1 take mantissa bits 4:1, and higher segments take the 4 bits below the leading one. The result is XORed with 0xD5 for non-negative input and with 0x55 for negative input.
- R7: Configuration bits 7:4 hold W-1, where W is the sample width used by codes 00 and 01. Field values 0 and 1 give W = 3.
- R8: Configuration bit 1 picks the bit order: 0 sends the MSB of the frame first and 1 sends the LSB first.
- R9: Each bit is held for DIV clocks. `fs_out` is high for exactly the first bit of a frame. `tx_irq` pulses in the cycle that `fs_out` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: [7:4] width-1, [3:2] format, [1] LSB first, [0] enable |
| dat_we | input | 1 | Transmit data register write strobe |
| dat_wdata | input | DATA_W | Data word |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for serial data |
| fs_out | output | 1 | Frame sync, high during the first bit |
| fs_oe | output | 1 | Output enable for frame sync |
| tx_irq | output | 1 | One-cycle transmit-empty interrupt pulse |

## Verification
The hardest situation to reach is full coverage of the two compressors. Their segment and mantissa corners show up only after a complete serial frame has been captured, so reaching every input code through the port would take millions of cycles. The bench therefore drives all 65536 inputs through separate encoder instances. It compares each result with a table-search reference, and random frames through the port then confirm that the encoders are wired into the datapath. A second hard case is switching the port off partway through a frame and then on again. The bench waits for a frame sync, cuts the enable in the middle of the second bit and checks that nothing is driven. After re-enabling, it checks that no stale frame appears.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [1:0] {
        FMT_ZERO  = 2'b00,
        FMT_SIGN  = 2'b01,
        FMT_MULAW = 2'b10,
        FMT_ALAW  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_SHIFT
    } st_e;

    typedef struct packed {
        logic [3:0] wm1;
        fmt_e       fmt;
        logic       lsb_first;
        logic       en;
    } cfg_t;

endpackage

// File: rtl/ser_tx_compand.sv
module ser_tx_compand #(
    parameter bit ALAW = 1'b0
) (
    input  logic [15:0] din,
    output logic [7:0]  code
);

    generate
        if (ALAW) begin : g_alaw
            logic [15:0] sh;
            logic [15:0] mag;
            logic [2:0]  seg;
            logic [3:0]  part;
            always_comb begin
                sh  = $signed(din) >>> 3;
                mag = sh[15] ? ~sh : sh;
                seg = 3'd0;
                for (int i = 5; i <= 11; i++) begin
                    if (mag[i]) seg = 3'(i - 4);
                end
                part = (seg < 3'd2) ? 4'(mag >> 1) : 4'(mag >> seg);
                code = {~sh[15], {seg, part} ^ 7'h55};
            end
        end else begin : g_mulaw
            logic signed [15:0] sh;
            logic [15:0] mag;
            logic [15:0] biased;
            logic [3:0]  seg;
            logic [3:0]  part;
            logic [6:0]  body;
            always_comb begin
                sh  = $signed(din) >>> 2;
                mag = sh[15] ? 16'(-sh) : 16'(sh);
                if (mag > 16'd8159) mag = 16'd8159;
                biased = mag + 16'd33;
                seg = 4'd0;
                for (int i = 6; i <= 13; i++) begin
                    if (biased[i]) seg = 4'(i - 5);
                end
                part = 4'(biased >> (seg + 4'd1));
                body = seg[3] ? 7'h7F : {seg[2:0], part};
                code = {~sh[15], ~body};
            end
        end
    endgenerate

endmodule

// File: rtl/ser_tx_format.sv
module ser_tx_format
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WID_W  = 4,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  fmt_e              fmt,
    input  logic [WID_W-1:0]  wm1,
    output logic [DATA_W-1:0] word,
    output logic [IDX_W-1:0]  len_m1
);

    localparam int CODE_W = 8;

    logic [CODE_W-1:0] mu_code;
    logic [CODE_W-1:0] a_code;
    logic [WID_W:0]    w;
    logic [DATA_W-1:0] lin;

    ser_tx_compand #(.ALAW(1'b0)) u_mu (.din(din[15:0]), .code(mu_code));
    ser_tx_compand #(.ALAW(1'b1)) u_a  (.din(din[15:0]), .code(a_code));

    always_comb begin
        w = (wm1 < WID_W'(2)) ? (WID_W+1)'(3) : ({1'b0, wm1} + 1'b1);
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(w)) lin[i] = din[i];
            else             lin[i] = (fmt == FMT_SIGN) && din[w - 1'b1];
        end
    end

    always_comb begin
        unique case (fmt)
            FMT_MULAW: begin
                word   = DATA_W'(mu_code);
                len_m1 = IDX_W'(CODE_W - 1);
            end
            FMT_ALAW: begin
                word   = DATA_W'(a_code);
                len_m1 = IDX_W'(CODE_W - 1);
            end
            default: begin
                word   = lin;
                len_m1 = IDX_W'(DATA_W - 1);
            end
        endcase
    end

endmodule

// File: rtl/ser_tx_bitclk.sv
module ser_tx_bitclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (!run)                     cnt <= '0;
        else if (cnt == CNT_W'(DIV - 1))   cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CNT_W'(DIV - 1));

endmodule

// File: rtl/ser_tx_fmt.sv
module ser_tx_fmt
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              fs_out,
    output logic              fs_oe,
    output logic              tx_irq
);

    localparam int IDX_W = $clog2(DATA_W);

    cfg_t              cfg_q;
    st_e               st, st_nx;
    logic              en, tick, load, fin;
    logic [DATA_W-1:0] dat_q, fmt_word, word_q;
    logic [IDX_W-1:0]  fmt_len_m1, idx_q, left_q;
    logic              full_q, dir_q, fs_q, irq_q;

    assign en = cfg_q.en;

    ser_tx_bitclk #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(en), .tick(tick)
    );

    ser_tx_format #(.DATA_W(DATA_W), .WID_W(4)) u_fmt (
        .din(dat_q), .fmt(cfg_q.fmt), .wm1(cfg_q.wm1),
        .word(fmt_word), .len_m1(fmt_len_m1)
    );

    assign load = (st == ST_IDLE)  && tick && full_q;
    assign fin  = (st == ST_SHIFT) && tick && (left_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (!en) begin
            st_nx = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:   st_nx = ST_IDLE;
                ST_IDLE:  st_nx = load ? ST_SHIFT : ST_IDLE;
                ST_SHIFT: st_nx = fin  ? ST_IDLE  : ST_SHIFT;
                default:  st_nx = ST_OFF;
            endcase
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            dat_q  <= '0;
            full_q <= 1'b0;
            word_q <= '0;
            idx_q  <= '0;
            left_q <= '0;
            dir_q  <= 1'b0;
            fs_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= (cfg_we && cfg_wdata[0] && !en) || load;
            if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
            if (!en) begin
                full_q <= 1'b0;
                fs_q   <= 1'b0;
            end else begin
                if (load) begin
                    word_q <= fmt_word;
                    dir_q  <= cfg_q.lsb_first;
                    idx_q  <= cfg_q.lsb_first ? '0 : fmt_len_m1;
                    left_q <= fmt_len_m1;
                    fs_q   <= 1'b1;
                end else if (st == ST_SHIFT && tick) begin
                    fs_q <= 1'b0;
                    if (left_q != '0) begin
                        left_q <= left_q - 1'b1;
                        idx_q  <= dir_q ? idx_q + 1'b1 : idx_q - 1'b1;
                    end
                end
                if (dat_we) begin
                    dat_q  <= dat_wdata;
                    full_q <= 1'b1;
                end else if (load) begin
                    full_q <= 1'b0;
                end
            end
        end
    end

    assign sd_oe  = en;
    assign fs_oe  = en;
    assign sd_out = en && (st == ST_SHIFT) && word_q[idx_q];
    assign fs_out = en && fs_q;
    assign tx_irq = irq_q;

endmodule

// File: rtl/ser_tx_fmt_chk.sv
module ser_tx_fmt_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic cfg_en_bit,
    input logic sd_out,
    input logic sd_oe,
    input logic fs_out,
    input logic fs_oe,
    input logic tx_irq
);

    // R1
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> (!fs_oe && !sd_out && !fs_out));

    // R1
    a_r1_disable_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en_bit) |=> (!sd_oe && !fs_out && !sd_out));

    // R2
    a_r2_irq_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_en_bit && !sd_oe) |=> (tx_irq && sd_oe));

    // R9
    a_r9_frame_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> tx_irq);

    // R2, R9
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (fs_out || $rose(sd_oe)));

endmodule

bind ser_tx_fmt ser_tx_fmt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en_bit(cfg_wdata[0]),
    .sd_out(sd_out), .sd_oe(sd_oe), .fs_out(fs_out), .fs_oe(fs_oe),
    .tx_irq(tx_irq)
);

// File: tb/ser_tx_fmt_tb_top.sv
`timescale 1ns/1ps
module ser_tx_fmt_tb_top;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        dat_we = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic        sd_out, sd_oe, fs_out, fs_oe, tx_irq;
    logic [15:0] cmp_in = '0;
    logic [7:0]  mu_out, a_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ser_tx_fmt #(.DATA_W(16), .DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .sd_out(sd_out), .sd_oe(sd_oe),
        .fs_out(fs_out), .fs_oe(fs_oe), .tx_irq(tx_irq)
    );

    ser_tx_compand #(.ALAW(1'b0)) enc_mu_i (.din(cmp_in), .code(mu_out));
    ser_tx_compand #(.ALAW(1'b1)) enc_a_i  (.din(cmp_in), .code(a_out));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mulaw(input logic [15:0] x);
        int p, mask, seg, r;
        p = int'($signed(x)) >>> 2;
        if (p < 0) begin p = -p; mask = 'h7F; end
        else mask = 'hFF;
        if (p > 8159) p = 8159;
        p = p + 33;
        seg = 8;
        for (int i = 7; i >= 0; i--) if (p <= (64 << i) - 1) seg = i;
        if (seg == 8) r = 'h7F;
        else r = (seg << 4) | ((p >> (seg + 1)) & 15);
        return 8'(r ^ mask);
    endfunction

    function automatic logic [7:0] ref_alaw(input logic [15:0] x);
        int p, mask, seg, r;
        p = int'($signed(x)) >>> 3;
        if (p >= 0) mask = 'hD5;
        else begin mask = 'h55; p = -p - 1; end
        seg = 8;
        for (int i = 7; i >= 0; i--) if (p <= (32 << i) - 1) seg = i;
        if (seg == 8) r = 'h7F;
        else if (seg < 2) r = (seg << 4) | ((p >> 1) & 15);
        else r = (seg << 4) | ((p >> seg) & 15);
        return 8'(r ^ mask);
    endfunction

    function automatic logic [15:0] ref_word(input logic [15:0] d, input int fmt, input int wm1);
        int w;
        logic [15:0] m;
        if (fmt == 2) return {8'h00, ref_mulaw(d)};
        if (fmt == 3) return {8'h00, ref_alaw(d)};
        w = (wm1 < 2) ? 3 : wm1 + 1;
        m = 16'((32'd1 << w) - 1);
        if (fmt == 1 && d[w-1]) return (d & m) | ~m;
        return d & m;
    endfunction

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic dat_write(input logic [15:0] v);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = v;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic wait_fs(output bit found);
        bit prev;
        found = 1'b0;
        prev = fs_out;
        for (int k = 0; k < 80 * DIV; k++) begin
            @(negedge clk);
            if (fs_out && !prev) begin found = 1'b1; break; end
            prev = fs_out;
        end
    endtask

    task automatic expect_frame(input logic [15:0] exp, input int len, input bit lsb, input string req);
        bit found;
        logic [15:0] got;
        wait_fs(found);
        chk(found, {req, " frame start"}, found, 1);
        if (!found) return;
        chk(tx_irq == 1'b1, "R9 irq at load", tx_irq, 1);
        chk(sd_oe && fs_oe, "R1 oe while enabled", sd_oe, 1);
        got = '0;
        for (int b = 0; b < len; b++) begin
            if (b > 0) repeat (DIV) @(negedge clk);
            if (b == 1) chk(fs_out == 1'b0, "R9 fs one bit", fs_out, 0);
            if (lsb) got[b] = sd_out;
            else     got[len - 1 - b] = sd_out;
        end
        chk(got == exp, {req, (lsb ? " R8 lsb-first" : " R8 msb-first")}, got, exp);
    endtask

    task automatic expect_silence(input string req);
        bit found;
        wait_fs(found);
        chk(!found, req, found, 0);
    endtask

    task automatic send(input int fmt, input int wm1, input bit lsb, input logic [15:0] d, input string req);
        cfg_write({4'(wm1), 2'(fmt), lsb, 1'b1});
        dat_write(d);
        expect_frame(ref_word(d, fmt, wm1), (fmt >= 2) ? 8 : 16, lsb, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        bit found;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!sd_oe && !fs_oe && !sd_out && !fs_out && !tx_irq, "R1 reset quiet",
            {sd_oe, fs_oe, sd_out, fs_out, tx_irq}, 0);
        rst_n = 1'b1;

        // R5 R6: exhaustive encoder comparison
        for (int k = 0; k < 65536; k++) begin
            cmp_in = 16'(k);
            #1;
            chk(mu_out == ref_mulaw(cmp_in), "R5 mu-law", mu_out, ref_mulaw(cmp_in));
            chk(a_out == ref_alaw(cmp_in), "R6 A-law", a_out, ref_alaw(cmp_in));
        end

        // R1: data written while off is ignored
        dat_write(16'h1234);
        chk(!sd_oe && !fs_out, "R1 off after write", sd_oe, 0);
        cfg_write(8'hF1);
        chk(tx_irq == 1'b1, "R2 irq on enable", tx_irq, 1);
        chk(sd_oe && fs_oe, "R2 oe on enable", sd_oe, 1);
        @(negedge clk);
        chk(tx_irq == 1'b0, "R2 irq one cycle", tx_irq, 0);
        expect_silence("R1 write while off dropped");

        // directed corners
        send(0, 7, 1'b0, 16'hFFAB, "R3");
        send(1, 7, 1'b0, 16'h0080, "R4");
        send(1, 7, 1'b0, 16'h007F, "R4");
        send(1, 0, 1'b0, 16'h0004, "R7");
        send(1, 1, 1'b1, 16'h0003, "R7");
        send(0, 0, 1'b1, 16'hFFFF, "R7");
        send(0, 15, 1'b1, 16'hA5C3, "R3");
        send(2, 3, 1'b0, 16'h8000, "R5");
        send(2, 3, 1'b1, 16'h0000, "R5");
        send(3, 3, 1'b0, 16'h7FFF, "R6");
        send(3, 3, 1'b1, 16'hFFFF, "R6");

        // random frames
        for (int n = 0; n < 60; n++) begin
            int fmt, wm1;
            string req;
            fmt = int'($urandom % 4);
            wm1 = int'($urandom % 16);
            req = (fmt == 0) ? "R3" : (fmt == 1) ? "R4" : (fmt == 2) ? "R5" : "R6";
            send(fmt, wm1, 1'($urandom % 2), 16'($urandom), req);
        end

        // R1: disable in mid-frame, then re-enable with nothing pending
        cfg_write(8'h71);
        dat_write(16'h5A5A);
        wait_fs(found);
        chk(found, "R9 frame before disable", found, 1);
        repeat (DIV) @(negedge clk);
        cfg_write(8'h70);
        chk(!sd_oe && !fs_oe && !sd_out && !fs_out, "R1 disable mid-frame",
            {sd_oe, fs_oe, sd_out, fs_out}, 0);
        repeat (3 * DIV) @(negedge clk);
        chk(!sd_oe && !sd_out && !tx_irq, "R1 stays off", {sd_oe, sd_out, tx_irq}, 0);
        cfg_write(8'h71);
        chk(tx_irq == 1'b1, "R2 irq on re-enable", tx_irq, 1);
        expect_silence("R1 pending word discarded");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule